// File: doc/BRIEF.md
# Idle-Stress-Balancing Wordline Decoder Front End

This block registers the row address of a 128-row memory array and decodes it into one-hot wordlines. The address register is fed by a two-way selector driven by the memory enable. During an access cycle (enable high) the selector passes the host address. During an idle cycle (enable low) it passes a hardwired all-ones address. The idle address leaves only the fastest output of every predecoder active: this is the output whose inputs all come from true address bits, with no inverted bit on the path. The slower paths that go through an inverted bit are left at rest while the memory is idle.

Decoding has two levels. Three predecoders each take their own slice of the registered address. The 128 final AND gates each combine one output from every predecoder with the decoder enable that comes from the timing logic. The predecoder outputs are also brought out as ports so they can be observed. A parameter removes the selector, so that the register keeps the last host address through idle cycles and the unmitigated behaviour can be compared.

Top module: `idle_stress_wl_decoder`

## Requirements
- R1: While `rst_ni` is low, the address register holds all ones. It therefore selects predecoder outputs `pre_a_o[7]`, `pre_b_o[3]` and `pre_c_o[3]`.
- R2: At a rising clock edge where `mem_en_i` is high, the register loads `host_addr_i`. From that edge on, the wordline index equals the loaded address value.
- R3: With `MITIGATE` = 1, at a rising clock edge where `mem_en_i` is low, the register loads 7'h7F no matter what `host_addr_i` holds.
- R4: Address bits [2:0] select the index of the hot bit in `pre_a_o`. Bits [4:3] select it in `pre_b_o`, and bits [6:5] select it in `pre_c_o`.
- R5: Each predecoder output group is exactly one-hot at all times after reset. This holds whatever the value of `dec_en_i`.
- R6: All wordlines are low whenever `dec_en_i` is low. A wordline responds to `dec_en_i` in the same cycle, with no register on that path.
- R7: At most one wordline is high in any cycle.
- R8: With `MITIGATE` = 0, the register keeps its value on every edge where `mem_en_i` is low. The last host address therefore stays selected through idle cycles.
- R9: Wordline n is high exactly when `dec_en_i` is high and the predecoder outputs n[2:0], n[4:3] and n[6:5] are all active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the idle address |
| host_addr_i | input | 7 | Row address from the host |
| mem_en_i | input | 1 | Memory enable; high selects the host address, low selects the idle address |
| dec_en_i | input | 1 | Decoder enable from the timing logic; gates the final AND stage |
| wordline_o | output | 128 | One-hot wordlines |
| pre_a_o | output | 8 | Outputs of the predecoder for address bits [2:0] |
| pre_b_o | output | 4 | Outputs of the predecoder for address bits [4:3] |
| pre_c_o | output | 4 | Outputs of the predecoder for address bits [6:5] |

## Verification
The idle-address load and the decoder-enable gating can both act in the same cycle. The bench provokes this by dropping `mem_en_i` while holding `dec_en_i` high, so the only wordline that rises is 127 and never the previous host row. The same stimulus goes to a second instance built with `MITIGATE` = 0. On that instance the earlier host row must stay selected, and in both instances the predecoder groups must stay one-hot while `dec_en_i` toggles.

// File: rtl/wl_dec_pkg.sv
package wl_dec_pkg;
  localparam int unsigned GA_W   = 3;
  localparam int unsigned GB_W   = 2;
  localparam int unsigned GC_W   = 2;
  localparam int unsigned ADDR_W = GA_W + GB_W + GC_W;
  localparam int unsigned ROWS   = 1 << ADDR_W;
  localparam int unsigned GA_N   = 1 << GA_W;
  localparam int unsigned GB_N   = 1 << GB_W;
  localparam int unsigned GC_N   = 1 << GC_W;
  localparam logic [ADDR_W-1:0] IDLE_ADDR = '1;
endpackage

// File: rtl/wl_predec.sv
module wl_predec #(
  parameter int unsigned IN_W = 2
) (
  input  logic [IN_W-1:0]      sel_i,
  output logic [(1<<IN_W)-1:0] hot_o
);
  localparam int unsigned OUT_N = 1 << IN_W;

  for (genvar k = 0; k < OUT_N; k++) begin : g_out
    localparam logic [IN_W-1:0] K = IN_W'(k);
    assign hot_o[k] = (sel_i == K);
  end
endmodule

// File: rtl/wl_post_array.sv
module wl_post_array
  import wl_dec_pkg::*;
(
  input  logic [GA_N-1:0] pre_a_i,
  input  logic [GB_N-1:0] pre_b_i,
  input  logic [GC_N-1:0] pre_c_i,
  input  logic            en_i,
  output logic [ROWS-1:0] wl_o
);
  for (genvar n = 0; n < ROWS; n++) begin : g_row
    localparam int unsigned IA = n % GA_N;
    localparam int unsigned IB = (n / GA_N) % GB_N;
    localparam int unsigned IC = n / (GA_N * GB_N);
    assign wl_o[n] = pre_a_i[IA] & pre_b_i[IB] & pre_c_i[IC] & en_i;
  end
endmodule

// File: rtl/idle_stress_wl_decoder.sv
module idle_stress_wl_decoder
  import wl_dec_pkg::*;
#(
  parameter bit MITIGATE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              mem_en_i,
  input  logic              dec_en_i,
  output logic [ROWS-1:0]   wordline_o,
  output logic [GA_N-1:0]   pre_a_o,
  output logic [GB_N-1:0]   pre_b_o,
  output logic [GC_N-1:0]   pre_c_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  if (MITIGATE) begin : g_mux
    assign addr_d = mem_en_i ? host_addr_i : IDLE_ADDR;
  end else begin : g_hold
    assign addr_d = mem_en_i ? host_addr_i : addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= IDLE_ADDR;
    else         addr_q <= addr_d;
  end

  wl_predec #(.IN_W(GA_W)) u_pre_a (
    .sel_i (addr_q[GA_W-1:0]),
    .hot_o (pre_a_o)
  );
  wl_predec #(.IN_W(GB_W)) u_pre_b (
    .sel_i (addr_q[GA_W+GB_W-1:GA_W]),
    .hot_o (pre_b_o)
  );
  wl_predec #(.IN_W(GC_W)) u_pre_c (
    .sel_i (addr_q[ADDR_W-1:GA_W+GB_W]),
    .hot_o (pre_c_o)
  );

  wl_post_array u_post (
    .pre_a_i (pre_a_o),
    .pre_b_i (pre_b_o),
    .pre_c_i (pre_c_o),
    .en_i    (dec_en_i),
    .wl_o    (wordline_o)
  );

  AST_HOST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_i |=> addr_q == $past(host_addr_i)); // R2

  if (MITIGATE) begin : g_ast_mit
    AST_IDLE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_en_i |=> (pre_a_o[GA_N-1] && pre_b_o[GB_N-1] && pre_c_o[GC_N-1])); // R3
  end else begin : g_ast_hold
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_en_i |=> $stable(addr_q)); // R8
  end

  AST_PRE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(pre_a_o) && $onehot(pre_b_o) && $onehot(pre_c_o)); // R5
  AST_WL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_en_i |-> wordline_o == '0); // R6
  AST_WL_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wordline_o)); // R7
  AST_WL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_en_i |-> wordline_o[addr_q]); // R9
endmodule

// File: tb/idle_stress_wl_decoder_test.sv
module idle_stress_wl_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [6:0]   haddr = 7'h00;
  logic         men = 1'b0;
  logic         den = 1'b0;
  logic [127:0] wl_m, wl_h;
  logic [7:0]   pa_m, pa_h;
  logic [3:0]   pb_m, pb_h, pc_m, pc_h;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  idle_stress_wl_decoder #(.MITIGATE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(haddr), .mem_en_i(men),
    .dec_en_i(den), .wordline_o(wl_m), .pre_a_o(pa_m), .pre_b_o(pb_m), .pre_c_o(pc_m));

  idle_stress_wl_decoder #(.MITIGATE(1'b0)) uut_nomit (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(haddr), .mem_en_i(men),
    .dec_en_i(den), .wordline_o(wl_h), .pre_a_o(pa_h), .pre_b_o(pb_h), .pre_c_o(pc_h));

  function automatic logic [127:0] exp_wl(input logic [6:0] a, input logic d);
    return d ? (128'b1 << a) : 128'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all outputs of one instance against an expected address
  task automatic chk_inst(input bit mit, input logic [6:0] a, input string req);
    logic [127:0] w;
    logic [7:0] pa;
    logic [3:0] pb, pc;
    w  = mit ? wl_m : wl_h;
    pa = mit ? pa_m : pa_h;
    pb = mit ? pb_m : pb_h;
    pc = mit ? pc_m : pc_h;
    chk(w == exp_wl(a, den), req, w, exp_wl(a, den));
    chk({pc, pb, pa} == {4'b1 << a[6:5], 4'b1 << a[4:3], 8'b1 << a[2:0]},
        {req, " R4 R5 predecode"}, {112'b0, pc, pb, pa},
        {112'b0, 4'b1 << a[6:5], 4'b1 << a[4:3], 8'b1 << a[2:0]});
  endtask

  task automatic step(input logic m, input logic [6:0] a, input logic d);
    @(negedge clk);
    men = m; haddr = a; den = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    den = 1'b1; men = 1'b1; haddr = 7'h15;
    repeat (2) @(posedge clk);
    #1;
    chk_inst(1'b1, 7'h7F, "R1 reset mit");
    chk_inst(1'b0, 7'h7F, "R1 reset hold");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_host;
    logic [6:0] pat [6] = '{7'h00, 7'h01, 7'h2A, 7'h55, 7'h40, 7'h7E};
    foreach (pat[i]) begin
      step(1'b1, pat[i], 1'b1);
      chk_inst(1'b1, pat[i], "R2 R9 host access");
      chk_inst(1'b0, pat[i], "R2 host access nomit");
      chk($countones(wl_m) == 1, "R7 single wordline", {96'b0, 32'($countones(wl_m))}, 128'd1);
    end
  endtask

  task automatic t_gate;
    step(1'b1, 7'h33, 1'b0);
    chk(wl_m == '0, "R6 gated off", wl_m, 128'b0);
    chk_inst(1'b1, 7'h33, "R5 predecode while gated");
    #1 den = 1'b1;
    #1 chk(wl_m == exp_wl(7'h33, 1'b1), "R6 same-cycle enable", wl_m, exp_wl(7'h33, 1'b1));
  endtask

  task automatic t_idle;
    step(1'b1, 7'h12, 1'b1);
    step(1'b0, 7'h12, 1'b1);
    chk_inst(1'b1, 7'h7F, "R3 idle load with enable");
    chk_inst(1'b0, 7'h12, "R8 hold last host");
    step(1'b0, 7'h04, 1'b0);
    chk_inst(1'b1, 7'h7F, "R3 idle ignores host addr");
    chk_inst(1'b0, 7'h12, "R8 hold ignores host addr");
    chk(wl_m == '0 && wl_h == '0, "R6 idle gated", wl_m | wl_h, 128'b0);
    step(1'b1, 7'h09, 1'b1);
    chk_inst(1'b1, 7'h09, "R2 resume after idle");
    chk_inst(1'b0, 7'h09, "R2 resume after idle nomit");
  endtask

  initial begin
    t_reset();
    t_host();
    t_gate();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule